// File: doc/BRIEF.md
# Paged DIO Port Register File

This block is the host-facing register file of a 48-line general-purpose I/O unit. A host reaches it through a 4-bit address, an 8-bit data bus and single-cycle read and write strobes. Six byte-wide port registers control open-drain drivers. Writing a 1 to a bit pulls that line low. Writing a 0 releases the line, so an external pull-up holds it high and the line can act as an input. Reading a port returns the synchronized pin levels inverted.

A control byte selects one of four pages and holds one write-lock flag per port. Three paged slots open onto the polarity, enable and interrupt-identification banks of a separate edge-detect unit, each 24 bits wide. The page selects which bank the slots reach. A 24-bit bank is moved as three byte accesses, with the least significant byte at the lowest slot. The edge-detect unit reads the polarity and enable banks and sets bits in the identification bank. The host clears identification bits by writing the bank. A summary byte shows, for each byte of the identification bank, whether any bit in that byte is set.

Top module: `paged_dio_regs`

## Requirements
- R1: After reset, `drive_low`, `pol_q`, `enab_q` and `irq_id_q` are all zero, and reads of offsets 6 and 7 return 0x00.
- R2: A write to offset p (0 to 5) on any page stores `wdata` into port p. From the next cycle, `drive_low[8p+7:8p]` equals that byte: a 1 drives the line low and a 0 releases it. This applies only when lock flag p is clear.
- R3: A read of offset p (0 to 5) on any page returns `~pin_in[8p+7:8p]`.
- R4: Offset 7 holds the page in bits 7:6 and the lock flag of port p in bit p. While lock flag p is set, writes to port p are ignored, and reads of port p still return the inverted pins.
- R5: A write to offset 7 stores the whole byte, and a read of offset 7 returns it.
- R6: Offset 8+k (k = 0 to 2) holds bits 8k+7:8k of a 24-bit bank. Page 1 selects polarity (`pol_q`), page 2 selects enable (`enab_q`) and page 3 selects interrupt identification (`irq_id_q`). Writes store the byte into the selected bank and reads return it.
- R7: On page 0, offsets 8 to 10 read 0x00. On every page, offsets 11 to 15 read 0x00. Writes to any of these addresses change no output and no readable register.
- R8: A 1 on `id_set[i]` sets `irq_id_q[i]` from the next cycle. The bit stays set until a page-3 host write clears it. If `id_set[i]` and a host write to the same bit happen in the same cycle, the bit ends up set.
- R9: A read of offset 6 on any page returns a byte in which bit k (k = 0 to 2) is the OR of `irq_id_q[8k+7:8k]` and bits 7:3 are zero.
- R10: `rdata` takes the addressed value at the clock edge on which `rd_en` is high. It holds that value in every cycle in which `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rdata | output | 8 | Read data, registered |
| pin_in | input | 48 | Synchronized pin levels |
| drive_low | output | 48 | Per-line pull-low enables |
| id_set | input | 24 | Edge-detect unit requests to set identification bits |
| pol_q | output | 24 | Polarity bank |
| enab_q | output | 24 | Enable bank |
| irq_id_q | output | 24 | Interrupt-identification bank |

## Verification
The hardest case to reach is a set request from the edge-detect unit arriving in the same cycle as a host write to the same identification byte. To get there, the page is first switched to 3. Then `id_set` and the write strobe are raised together with clearing data, and the bench checks that the requested bit survives while the other bits are cleared. Per-port locking is swept one port at a time, with every port written while one lock is set. This confirms that the lock blocks only its own port and that reads of the locked port still reflect the pins. Every address is written and read on every page, which covers the unimplemented slots.

// File: rtl/paged_dio_regs.sv
`timescale 1ns/1ps
module paged_dio_regs #(
  parameter int NPORT  = 6,
  parameter int NPAGED = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [3:0]            addr,
  input  logic [7:0]            wdata,
  input  logic                  wr_en,
  input  logic                  rd_en,
  output logic [7:0]            rdata,
  input  logic [NPORT*8-1:0]    pin_in,
  output logic [NPORT*8-1:0]    drive_low,
  input  logic [NPAGED*8-1:0]   id_set,
  output logic [NPAGED*8-1:0]   pol_q,
  output logic [NPAGED*8-1:0]   enab_q,
  output logic [NPAGED*8-1:0]   irq_id_q
);
  localparam logic [3:0] PEND_OFS = 4'd6;
  localparam logic [3:0] CTRL_OFS = 4'd7;
  localparam int         SLOT0    = 8;

  logic [7:0]        ctrl_q;
  logic [7:0]        rd_mux;
  logic [NPAGED-1:0] pend_bits;
  wire  [1:0]        page = ctrl_q[7:6];
  wire  [NPORT-1:0]  lock = ctrl_q[NPORT-1:0];

  always_ff @(posedge clk)
    if (!rst_n) ctrl_q <= '0;
    else if (wr_en && addr == CTRL_OFS) ctrl_q <= wdata;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    always_ff @(posedge clk)
      if (!rst_n) drive_low[p*8 +: 8] <= '0;
      else if (wr_en && addr == 4'(p) && !lock[p]) drive_low[p*8 +: 8] <= wdata;

    a_r2_port_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && addr == 4'(p) && !lock[p] |=> drive_low[p*8 +: 8] == $past(wdata));
    a_r4_locked_port_holds: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && addr == 4'(p) && lock[p] |=> $stable(drive_low[p*8 +: 8]));
  end

  for (genvar k = 0; k < NPAGED; k++) begin : g_slot
    wire hit = wr_en && addr == 4'(SLOT0 + k);
    always_ff @(posedge clk)
      if (!rst_n) begin
        pol_q[k*8 +: 8]    <= '0;
        enab_q[k*8 +: 8]   <= '0;
        irq_id_q[k*8 +: 8] <= '0;
      end else begin
        if (hit && page == 2'd1) pol_q[k*8 +: 8]  <= wdata;
        if (hit && page == 2'd2) enab_q[k*8 +: 8] <= wdata;
        irq_id_q[k*8 +: 8] <= ((hit && page == 2'd3) ? wdata : irq_id_q[k*8 +: 8])
                              | id_set[k*8 +: 8];
      end
    assign pend_bits[k] = |irq_id_q[k*8 +: 8];
  end

  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NPORT; p++)
      if (addr == 4'(p)) rd_mux = ~pin_in[p*8 +: 8];
    if (addr == PEND_OFS) rd_mux = {{(8-NPAGED){1'b0}}, pend_bits};
    if (addr == CTRL_OFS) rd_mux = ctrl_q;
    for (int k = 0; k < NPAGED; k++)
      if (addr == 4'(SLOT0 + k))
        case (page)
          2'd1:    rd_mux = pol_q[k*8 +: 8];
          2'd2:    rd_mux = enab_q[k*8 +: 8];
          2'd3:    rd_mux = irq_id_q[k*8 +: 8];
          default: rd_mux = '0;
        endcase
  end

  always_ff @(posedge clk)
    if (!rst_n) rdata <= '0;
    else if (rd_en) rdata <= rd_mux;

  a_r10_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
  a_r7_page0_slots_inert: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr >= 4'(SLOT0) && page == 2'd0 |=> $stable(pol_q) && $stable(enab_q));
  a_r7_high_offsets_inert: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr >= 4'(SLOT0 + NPAGED) |=> $stable(pol_q) && $stable(enab_q) && $stable(drive_low));
  a_r8_id_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    |id_set |=> (irq_id_q & $past(id_set)) == $past(id_set));
  a_r5_ctrl_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == CTRL_OFS |=> ctrl_q == $past(wdata));
endmodule

// File: tb/paged_dio_regs_test.sv
`timescale 1ns/1ps
module paged_dio_regs_test;
  logic clk = 0, rst_n = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] rdata;
  logic [47:0] pin_in = 0, drive_low;
  logic [23:0] id_set = 0, pol_q, enab_q, irq_id_q;

  int checks = 0, failures = 0;
  logic [47:0] m_drv = 0;
  logic [23:0] m_pol = 0, m_en = 0, m_id = 0;
  logic [7:0]  m_ctl = 0;

  always #2.5 clk = ~clk;

  paged_dio_regs uut (.clk, .rst_n, .addr, .wdata, .wr_en, .rd_en, .rdata,
    .pin_in, .drive_low, .id_set, .pol_q, .enab_q, .irq_id_q);

  task automatic chk(string tag, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_wr(int a, logic [7:0] d);
    if (a < 6) begin
      if (!m_ctl[a]) m_drv[a*8 +: 8] = d;
    end else if (a == 7) m_ctl = d;
    else if (a >= 8 && a <= 10) begin
      case (m_ctl[7:6])
        2'd1: m_pol[(a-8)*8 +: 8] = d;
        2'd2: m_en[(a-8)*8 +: 8]  = d;
        2'd3: m_id[(a-8)*8 +: 8]  = d;
        default: ;
      endcase
    end
  endtask

  function automatic logic [7:0] model_rd(int a);
    if (a < 6) return ~pin_in[a*8 +: 8];
    if (a == 6) return {5'b0, |m_id[23:16], |m_id[15:8], |m_id[7:0]};
    if (a == 7) return m_ctl;
    if (a <= 10)
      case (m_ctl[7:6])
        2'd1: return m_pol[(a-8)*8 +: 8];
        2'd2: return m_en[(a-8)*8 +: 8];
        2'd3: return m_id[(a-8)*8 +: 8];
        default: return 8'h00;
      endcase
    return 8'h00;
  endfunction

  function automatic string tag_of(int a);
    if (a < 6) return "R3";
    if (a == 6) return "R9";
    if (a == 7) return "R5";
    if (a <= 10) return (m_ctl[7:6] == 0) ? "R7" : "R6";
    return "R7";
  endfunction

  task automatic wr(int a, logic [7:0] d, logic [23:0] set = 0);
    @(negedge clk);
    addr = 4'(a); wdata = d; wr_en = 1; id_set = set;
    model_wr(a, d);
    m_id = m_id | set;
    @(negedge clk);
    wr_en = 0; id_set = 0;
  endtask

  task automatic rd_chk(int a);
    logic [7:0] e;
    @(negedge clk);
    addr = 4'(a); rd_en = 1;
    e = model_rd(a);
    @(negedge clk);
    rd_en = 0;
    chk(tag_of(a), {40'b0, rdata}, {40'b0, e});
  endtask

  task automatic chk_outs(string tag);
    chk({tag, " drive_low"}, drive_low, m_drv);
    chk({tag, " pol"}, {24'b0, pol_q}, {24'b0, m_pol});
    chk({tag, " enab"}, {24'b0, enab_q}, {24'b0, m_en});
    chk({tag, " id"}, {24'b0, irq_id_q}, {24'b0, m_id});
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk_outs("R1");
    rd_chk(6); rd_chk(7);

    for (int pg = 0; pg < 4; pg++) begin
      wr(7, 8'(pg << 6));
      pin_in = {24'(pg * 24'h13579B), 24'(~(pg * 24'h2468AC))};
      for (int a = 0; a < 16; a++)
        if (a != 7) wr(a, 8'(a * 29 + pg * 71 + 5));
      chk_outs("R2 R6 R7 sweep");
      for (int a = 0; a < 16; a++) rd_chk(a);
    end

    for (int p = 0; p < 6; p++) begin
      wr(7, 8'(1 << p));
      pin_in = 48'hA5C3_0FF0_5A3C ^ {8{8'(p * 17)}};
      for (int a = 0; a < 6; a++) wr(a, 8'(a * 13 + p * 41 + 1));
      chk("R4 lock", drive_low, m_drv);
      for (int a = 0; a < 6; a++) rd_chk(a);
      rd_chk(7);
    end

    wr(7, 8'hC0);
    for (int k = 0; k < 3; k++) wr(8 + k, 8'h00);
    wr(8, 8'h00, 24'h010000);
    chk("R8 set", {24'b0, irq_id_q}, {24'b0, m_id});
    rd_chk(6); rd_chk(10);
    wr(10, 8'h00, 24'h800000);
    chk("R8 set beats clear", {24'b0, irq_id_q}, {24'b0, m_id});
    wr(10, 8'hFF);
    wr(10, 8'h00, 24'h040000);
    chk("R8 same-cycle", {24'b0, irq_id_q}, {24'b0, m_id});
    rd_chk(6);
    wr(10, 8'h00);
    rd_chk(6);
    wr(0, 8'h00, 24'h000201);
    rd_chk(6);

    wr(7, 8'h5A);
    rd_chk(7);
    held = rdata;
    for (int a = 0; a < 16; a++) begin
      @(negedge clk); addr = 4'(a); pin_in = ~pin_in;
      chk("R10 hold", {40'b0, rdata}, {40'b0, held});
    end

    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    m_drv = 0; m_pol = 0; m_en = 0; m_id = 0; m_ctl = 0;
    chk_outs("R1 re-reset");
    rd_chk(7);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule